// File: doc/BRIEF.md
# Tone Parameter Loader with DMA Request

This block is the register front end of a tone generator, shaped so that a DMA engine can refill the tone parameters without processor help. Parameters reach it through a single staging port. A reload is a pair of 32-bit writes to that port. The first write of the pair fills the amplitude, frequency and tone-count registers. The second fills the time-cycle, ramp-step and PWM-period registers. A six-bit update mask decides which of the six targets a staging write may change.

A small control register holds a run bit, a DMA-mode bit and a request-enable bit. A one-bit clear port drops the pending status. Starting the block in DMA mode sets the status at once, so the DMA engine fetches the first parameter pair. After that, a down-counter of tone pulses sets the status again when it reaches zero, which asks for the next pair. The status, gated by the enable bit, drives the request line that triggers the DMA engine. The waveform and PWM stages are outside this block. They appear only as a one-cycle tone-pulse strobe input.

Top module: `tone_param_loader`

## Requirements
- R1: After reset, every parameter register, the pulse counter, the status bit, the request line and the pair phase are zero.
- R2: A staging write accepted in phase 0 loads amplitude from bits [7:0], frequency from bits [23:8] and tone count from bits [31:24], each where its mask bit is set, and moves the phase to 1 on the next cycle.
- R3: A staging write accepted in phase 1 loads time cycle from bits [7:0], ramp step from bits [15:8] and PWM period from bits [31:16], each where its mask bit is set. It returns the phase to 0 and reloads the pulse counter from the tone-count register.
- R4: Update-mask bit 0 gates amplitude, bit 1 frequency, bit 2 tone count, bit 3 time cycle, bit 4 ramp step and bit 5 PWM period. A target whose bit is clear keeps its value.
- R5: A control write with bit 0 (run) and bit 1 (DMA mode) both set makes the status 1 on the next cycle. The request line is 1 exactly when the status is 1 and control bit 2 (request enable) is set.
- R6: A clear-port write with data 1 makes the status 0 and the phase 0 on the next cycle, unless a set happens in the same cycle.
- R7: While running, each tone pulse decrements a non-zero pulse counter. The decrement that reaches zero sets the status. A pulse at zero leaves the counter at zero.
- R8: When a status set and a clear fall in the same cycle, the status becomes 1.
- R9: While the run bit is 0, staging writes change no register, tone pulses do not count, and the phase stays 0.
- R10: Any control write returns the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control data: bit 0 run, bit 1 DMA mode, bit 2 request enable |
| clr_we | input | 1 | Clear port write strobe |
| clr_wdata | input | 1 | Clear data; 1 drops the status |
| mask_we | input | 1 | Update-mask write strobe |
| mask_wdata | input | 6 | Update mask, one bit per target |
| stage_we | input | 1 | Staging port write strobe |
| stage_wdata | input | 32 | Staging data word |
| tone_pulse | input | 1 | One-cycle strobe from the tone stage |
| amplitude | output | 8 | Amplitude register |
| frequency | output | 16 | Frequency register |
| tone_count | output | 8 | Tone-count register |
| time_cycle | output | 8 | Time-cycle register |
| ramp_step | output | 8 | Increment/decrement step register |
| pwm_period | output | 16 | PWM period register |
| pulses_left | output | 8 | Pulse down-counter |
| irq_status | output | 1 | Pending status bit |
| dma_req | output | 1 | DMA request line |
| stage_phase | output | 1 | 0 when the next staging write is the first of a pair |

## Verification
A phase bit that drifts out of step sends the very next staging word to the wrong group. The wrong register changes one cycle after that write, so comparing all six parameter outputs after every write catches it at once. A counter that is off by one, or a reload from the wrong source, moves the status edge by one or more tone pulses. The bench therefore samples the counter and status after each pulse, not only at the end of a run. Errors in how set and clear are ordered can only be seen in the cycle where both happen, so the bench drives that cycle on purpose.

// File: rtl/tpl_pkg.sv
package tpl_pkg;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_DMA_BIT = 1;
    localparam int CTRL_IE_BIT  = 2;
    localparam int CTRL_W       = 3;
    localparam int N_TARGETS    = 6;
    localparam int PER_GROUP    = 3;

    typedef struct packed {
        logic run;
        logic dma;
        logic ie;
        logic phase;
    } ctrl_t;

endpackage

// File: rtl/tpl_stage_demux.sv
module tpl_stage_demux
    import tpl_pkg::*;
#(
    parameter int AMP_W  = 8,
    parameter int FREQ_W = 16,
    parameter int CNT_W  = 8,
    parameter int TIME_W = 8,
    parameter int STEP_W = 8,
    parameter int PWM_W  = 16,
    localparam int WORD_W = AMP_W + FREQ_W + CNT_W
) (
    input  logic                 accept,
    input  logic                 phase,
    input  logic [N_TARGETS-1:0] mask,
    input  logic [WORD_W-1:0]    wdata,
    output logic [N_TARGETS-1:0] load,
    output logic [AMP_W-1:0]     f_amp,
    output logic [FREQ_W-1:0]    f_freq,
    output logic [CNT_W-1:0]     f_cnt,
    output logic [TIME_W-1:0]    f_time,
    output logic [STEP_W-1:0]    f_step,
    output logic [PWM_W-1:0]     f_pwm
);

    localparam int FREQ_LSB = AMP_W;
    localparam int CNT_LSB  = AMP_W + FREQ_W;
    localparam int STEP_LSB = TIME_W;
    localparam int PWM_LSB  = TIME_W + STEP_W;

    // Target i belongs to the first group for i < PER_GROUP, the second otherwise.
    for (genvar i = 0; i < N_TARGETS; i++) begin : g_load
        localparam logic GROUP = (i >= PER_GROUP);
        assign load[i] = accept && mask[i] && (phase == GROUP);
    end

    always_comb begin
        f_amp  = wdata[AMP_W-1:0];
        f_freq = wdata[FREQ_LSB +: FREQ_W];
        f_cnt  = wdata[CNT_LSB +: CNT_W];
        f_time = wdata[TIME_W-1:0];
        f_step = wdata[STEP_LSB +: STEP_W];
        f_pwm  = wdata[PWM_LSB +: PWM_W];
    end

endmodule

// File: rtl/tpl_pulse_cnt.sv
module tpl_pulse_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             pulse,
    output logic [CNT_W-1:0] count,
    output logic             hit_zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d  = count_q;
        hit_zero = 1'b0;
        if (reload) begin
            count_d = reload_val;
        end else if (run && pulse && (count_q != '0)) begin
            count_d  = count_q - ONE;
            hit_zero = (count_q == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/tpl_irq.sv
module tpl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic enable,
    output logic status,
    output logic req
);

    logic status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (set_evt)      status_d = 1'b1;
        else if (clr_evt) status_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= status_d;
    end

    assign status = status_q;
    assign req    = status_q & enable;

endmodule

// File: rtl/tone_param_loader.sv
module tone_param_loader
    import tpl_pkg::*;
#(
    parameter int AMP_W  = 8,
    parameter int FREQ_W = 16,
    parameter int CNT_W  = 8,
    parameter int TIME_W = 8,
    parameter int STEP_W = 8,
    parameter int PWM_W  = 16,
    localparam int WORD_W = AMP_W + FREQ_W + CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic                 clr_we,
    input  logic                 clr_wdata,
    input  logic                 mask_we,
    input  logic [N_TARGETS-1:0] mask_wdata,
    input  logic                 stage_we,
    input  logic [WORD_W-1:0]    stage_wdata,
    input  logic                 tone_pulse,
    output logic [AMP_W-1:0]     amplitude,
    output logic [FREQ_W-1:0]    frequency,
    output logic [CNT_W-1:0]     tone_count,
    output logic [TIME_W-1:0]    time_cycle,
    output logic [STEP_W-1:0]    ramp_step,
    output logic [PWM_W-1:0]     pwm_period,
    output logic [CNT_W-1:0]     pulses_left,
    output logic                 irq_status,
    output logic                 dma_req,
    output logic                 stage_phase
);

    typedef struct packed {
        ctrl_t                ctrl;
        logic [N_TARGETS-1:0] mask;
        logic [AMP_W-1:0]     amp;
        logic [FREQ_W-1:0]    freq;
        logic [CNT_W-1:0]     cnt;
        logic [TIME_W-1:0]    tcyc;
        logic [STEP_W-1:0]    step;
        logic [PWM_W-1:0]     pwm;
    } state_t;

    state_t s_d, s_q;

    logic                 accept;
    logic                 clr_hit;
    logic                 start_dma;
    logic                 reload;
    logic                 hit_zero;
    logic [N_TARGETS-1:0] load;
    logic [AMP_W-1:0]     f_amp;
    logic [FREQ_W-1:0]    f_freq;
    logic [CNT_W-1:0]     f_cnt;
    logic [TIME_W-1:0]    f_time;
    logic [STEP_W-1:0]    f_step;
    logic [PWM_W-1:0]     f_pwm;

    assign accept    = stage_we && s_q.ctrl.run;
    assign clr_hit   = clr_we && clr_wdata;
    assign start_dma = ctrl_we && ctrl_wdata[CTRL_RUN_BIT] && ctrl_wdata[CTRL_DMA_BIT];
    assign reload    = accept && s_q.ctrl.phase;

    tpl_stage_demux #(
        .AMP_W(AMP_W), .FREQ_W(FREQ_W), .CNT_W(CNT_W),
        .TIME_W(TIME_W), .STEP_W(STEP_W), .PWM_W(PWM_W)
    ) u_demux (
        .accept (accept),
        .phase  (s_q.ctrl.phase),
        .mask   (s_q.mask),
        .wdata  (stage_wdata),
        .load   (load),
        .f_amp  (f_amp),
        .f_freq (f_freq),
        .f_cnt  (f_cnt),
        .f_time (f_time),
        .f_step (f_step),
        .f_pwm  (f_pwm)
    );

    always_comb begin
        s_d = s_q;
        if (mask_we) s_d.mask = mask_wdata;
        if (load[0]) s_d.amp  = f_amp;
        if (load[1]) s_d.freq = f_freq;
        if (load[2]) s_d.cnt  = f_cnt;
        if (load[3]) s_d.tcyc = f_time;
        if (load[4]) s_d.step = f_step;
        if (load[5]) s_d.pwm  = f_pwm;
        if (accept)  s_d.ctrl.phase = ~s_q.ctrl.phase;
        if (ctrl_we) begin
            s_d.ctrl.run   = ctrl_wdata[CTRL_RUN_BIT];
            s_d.ctrl.dma   = ctrl_wdata[CTRL_DMA_BIT];
            s_d.ctrl.ie    = ctrl_wdata[CTRL_IE_BIT];
            s_d.ctrl.phase = 1'b0;
        end
        if (clr_hit)         s_d.ctrl.phase = 1'b0;
        if (!s_d.ctrl.run)   s_d.ctrl.phase = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    tpl_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (s_q.ctrl.run),
        .reload     (reload),
        .reload_val (s_q.cnt),
        .pulse      (tone_pulse),
        .count      (pulses_left),
        .hit_zero   (hit_zero)
    );

    tpl_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (start_dma || hit_zero),
        .clr_evt (clr_hit),
        .enable  (s_q.ctrl.ie),
        .status  (irq_status),
        .req     (dma_req)
    );

    assign amplitude   = s_q.amp;
    assign frequency   = s_q.freq;
    assign tone_count  = s_q.cnt;
    assign time_cycle  = s_q.tcyc;
    assign ramp_step   = s_q.step;
    assign pwm_period  = s_q.pwm;
    assign stage_phase = s_q.ctrl.phase;

endmodule

// File: rtl/tpl_checker.sv
module tpl_checker #(
    parameter int AMP_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             ctrl_we,
    input logic [2:0]       ctrl_wdata,
    input logic             clr_we,
    input logic             clr_wdata,
    input logic             stage_we,
    input logic             tone_pulse,
    input logic [AMP_W-1:0] amplitude,
    input logic [CNT_W-1:0] pulses_left,
    input logic             irq_status,
    input logic             dma_req,
    input logic             stage_phase
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R5
    start_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && ctrl_wdata[0] && ctrl_wdata[1] |=> irq_status);

    // R5
    req_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> irq_status);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && clr_wdata && !ctrl_we && !tone_pulse |=> !irq_status && !stage_phase);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && clr_wdata && ctrl_we && ctrl_wdata[0] && ctrl_wdata[1] |=> irq_status);

    // R7
    zero_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && tone_pulse && pulses_left == ONE && !(stage_we && stage_phase)
        |=> irq_status && pulses_left == '0);

    // R9
    stopped_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(pulses_left));

    // R9
    stopped_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running && stage_we |=> $stable(amplitude) && !stage_phase);

    // R2
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && stage_we && !stage_phase && !ctrl_we && !(clr_we && clr_wdata)
        |=> stage_phase);

    // R10
    ctrl_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !stage_phase);

endmodule

bind tone_param_loader tpl_checker #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (s_q.ctrl.run),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .clr_we      (clr_we),
    .clr_wdata   (clr_wdata),
    .stage_we    (stage_we),
    .tone_pulse  (tone_pulse),
    .amplitude   (amplitude),
    .pulses_left (pulses_left),
    .irq_status  (irq_status),
    .dma_req     (dma_req),
    .stage_phase (stage_phase)
);

// File: tb/tone_param_loader_tb.sv
module tone_param_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_wdata = '0;
    logic        clr_we = 1'b0;
    logic        clr_wdata = 1'b0;
    logic        mask_we = 1'b0;
    logic [5:0]  mask_wdata = '0;
    logic        stage_we = 1'b0;
    logic [31:0] stage_wdata = '0;
    logic        tone_pulse = 1'b0;
    logic [7:0]  amplitude, tone_count, time_cycle, ramp_step, pulses_left;
    logic [15:0] frequency, pwm_period;
    logic        irq_status, dma_req, stage_phase;

    always #4 clk = ~clk;

    tone_param_loader u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .stage_we(stage_we), .stage_wdata(stage_wdata),
        .tone_pulse(tone_pulse),
        .amplitude(amplitude), .frequency(frequency), .tone_count(tone_count),
        .time_cycle(time_cycle), .ramp_step(ramp_step), .pwm_period(pwm_period),
        .pulses_left(pulses_left), .irq_status(irq_status), .dma_req(dma_req),
        .stage_phase(stage_phase)
    );

    typedef enum int {S_AMP, S_FREQ, S_CNT, S_TIME, S_STEP, S_PWM,
                      S_LEFT, S_STAT, S_REQ, S_PHASE} sel_t;
    typedef struct {
        int    due;
        sel_t  sel;
        int    val;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(sel_t s);
        case (s)
            S_AMP:   return int'(amplitude);
            S_FREQ:  return int'(frequency);
            S_CNT:   return int'(tone_count);
            S_TIME:  return int'(time_cycle);
            S_STEP:  return int'(ramp_step);
            S_PWM:   return int'(pwm_period);
            S_LEFT:  return int'(pulses_left);
            S_STAT:  return int'(irq_status);
            S_REQ:   return int'(dma_req);
            default: return int'(stage_phase);
        endcase
    endfunction

    // Monitor: pops every expectation that has come due and compares it.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = observe(it.sel);
            n_chk++;
            if (act != it.val) begin
                n_fail++;
                $display("FAIL %s %s: actual 0x%0h expected 0x%0h",
                         it.tag, it.sel.name(), act, it.val);
            end
        end
    end

    // Expectation for the cycle after the one being driven.
    task automatic expect_next(sel_t s, int v, string tag);
        q.push_back('{cyc + 1, s, v, tag});
    endtask

    task automatic drive(logic cw, logic [2:0] cd, logic kw, logic mw, logic [5:0] md,
                         logic sw, logic [31:0] sd, logic tp);
        @(negedge clk);
        ctrl_we = cw; ctrl_wdata = cd; clr_we = kw; clr_wdata = kw;
        mask_we = mw; mask_wdata = md; stage_we = sw; stage_wdata = sd;
        tone_pulse = tp;
    endtask

    task automatic idle();                 drive(0, 3'b0, 0, 0, 6'h0, 0, 32'h0, 0); endtask
    task automatic ctrl(logic [2:0] d);     drive(1, d,    0, 0, 6'h0, 0, 32'h0, 0); endtask
    task automatic clr();                   drive(0, 3'b0, 1, 0, 6'h0, 0, 32'h0, 0); endtask
    task automatic mask(logic [5:0] m);     drive(0, 3'b0, 0, 1, m,    0, 32'h0, 0); endtask
    task automatic stage(logic [31:0] w);   drive(0, 3'b0, 0, 0, 6'h0, 1, w,     0); endtask
    task automatic pulse();                 drive(0, 3'b0, 0, 0, 6'h0, 0, 32'h0, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        expect_next(S_AMP, 0, "R1"); expect_next(S_FREQ, 0, "R1");
        expect_next(S_PWM, 0, "R1"); expect_next(S_LEFT, 0, "R1");
        expect_next(S_STAT, 0, "R1"); expect_next(S_REQ, 0, "R1");
        expect_next(S_PHASE, 0, "R1");

        mask(6'h3F);
        // R9: staging ignored while stopped
        stage(32'h1234_5678);
        expect_next(S_AMP, 0, "R9"); expect_next(S_FREQ, 0, "R9");
        expect_next(S_PHASE, 0, "R9");

        // R5: start in DMA mode with enable raises status and request
        ctrl(3'b111);
        expect_next(S_STAT, 1, "R5"); expect_next(S_REQ, 1, "R5");
        expect_next(S_PHASE, 0, "R10");

        // R6: clear drops status
        clr();
        expect_next(S_STAT, 0, "R6"); expect_next(S_REQ, 0, "R6");

        // R2: first write of the pair
        stage(32'h0512_34AA);
        expect_next(S_AMP, 'hAA, "R2"); expect_next(S_FREQ, 'h1234, "R2");
        expect_next(S_CNT, 'h05, "R2"); expect_next(S_PHASE, 1, "R2");

        // R3: second write and counter reload
        stage(32'h0300_2010);
        expect_next(S_TIME, 'h10, "R3"); expect_next(S_STEP, 'h20, "R3");
        expect_next(S_PWM, 'h0300, "R3"); expect_next(S_LEFT, 5, "R3");
        expect_next(S_PHASE, 0, "R3");

        // R7: count down to zero
        for (int i = 0; i < 4; i++) pulse();
        expect_next(S_LEFT, 1, "R7"); expect_next(S_STAT, 0, "R7");
        pulse();
        expect_next(S_LEFT, 0, "R7"); expect_next(S_STAT, 1, "R7");
        expect_next(S_REQ, 1, "R7");
        pulse();
        expect_next(S_LEFT, 0, "R7");

        // R4: masked loads (frequency, time cycle, PWM period only)
        mask(6'b10_1010);
        clr();
        expect_next(S_STAT, 0, "R6");
        stage(32'h09BE_EF11);
        expect_next(S_AMP, 'hAA, "R4"); expect_next(S_FREQ, 'hBEEF, "R4");
        expect_next(S_CNT, 'h05, "R4");
        stage(32'hFFFF_7766);
        expect_next(S_TIME, 'h66, "R4"); expect_next(S_STEP, 'h20, "R4");
        expect_next(S_PWM, 'hFFFF, "R4"); expect_next(S_LEFT, 5, "R3");

        // R8: zero reached in the same cycle as a clear
        for (int i = 0; i < 4; i++) pulse();
        expect_next(S_LEFT, 1, "R7");
        drive(0, 3'b0, 1, 0, 6'h0, 0, 32'h0, 1);
        expect_next(S_STAT, 1, "R8"); expect_next(S_LEFT, 0, "R8");

        // R6: clear realigns the pair phase
        clr();
        stage(32'h0100_0000);
        expect_next(S_FREQ, 0, "R2"); expect_next(S_PHASE, 1, "R2");
        clr();
        expect_next(S_PHASE, 0, "R6");
        stage(32'h02AA_AA00);
        expect_next(S_FREQ, 'hAAAA, "R6"); expect_next(S_PHASE, 1, "R6");

        // R10: control write realigns the phase
        ctrl(3'b111);
        expect_next(S_PHASE, 0, "R10"); expect_next(S_STAT, 1, "R5");

        // R5: enable clear keeps request low while status is set
        clr();
        ctrl(3'b011);
        expect_next(S_STAT, 1, "R5"); expect_next(S_REQ, 0, "R5");

        // R9: stopped again
        ctrl(3'b000);
        stage(32'h0055_5500);
        expect_next(S_FREQ, 'hAAAA, "R9"); expect_next(S_PHASE, 0, "R9");
        pulse();
        expect_next(S_LEFT, 0, "R9");

        idle();
        repeat (3) idle();
        done = 1'b1;
    end

    initial begin
        int waited;
        waited = 0;
        while (!done && waited < 200000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule